// File: doc/BRIEF.md
# Debug Cross-Trigger Router

This block links debug event sources to event consumers through four shared broadcast channels. Each trigger input can be placed on any subset of the channels. Each trigger output can listen to any subset of the channels. An output goes high only when it shares a channel with an input that is high. Typical sources are core "halted" levels and event strobes. Typical sinks are general-purpose trigger lines toward a system trigger multiplexer. For example, input 4 carries a core-halted level, and outputs 6 and 7 feed the multiplexer.

A 32-bit register bus with a one-cycle response programs the block. It holds a global enable, one channel mask per input and one channel mask per output. The bus is usable only while a debugger-attached status input is high. When that input is low, the configured routing keeps running, but the registers cannot be read or changed. Trigger inputs are levels. They pass through a two-flop synchronizer, are OR-combined per channel, and the outputs are registered.

Top module: `xtrig_router`

## Requirements
- R1: After synchronous reset, every register reads zero and all trigger outputs are low.
- R2: Offset 0x00 is the control register. Its bit 0 is the global enable and reads back as written; bits 31:1 read zero.
- R3: Offset 0x20 + 4*i is the source mask of input i (i = 0..7). Bit n places input i on channel n. Only bits 3:0 are stored; bits 31:4 read zero.
- R4: Offset 0xA0 + 4*j is the sink mask of output j (j = 0..7). Bit n lets channel n drive output j. Only bits 3:0 are stored; bits 31:4 read zero.
- R5: Output j goes high when the block is enabled and some high input has a source mask that shares a set bit with sink mask j. It follows an input change by three clock edges: two synchronizer flops and one output register.
- R6: While the enable bit is 0, all trigger outputs are low. They go low one clock edge after the write that clears the enable takes effect.
- R7: While the debugger-attached input is low, bus writes change nothing and reads return zero. Routing that is already configured keeps driving the outputs.
- R8: An access to any other offset, including a misaligned one such as 0x21, reads zero and its write changes no register.
- R9: The acknowledge goes high exactly one clock edge after a request. Read data is valid in that same cycle and is zero in every other cycle.
- R10: Several inputs on one channel are OR-combined. An input and an output with no common channel never interact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dbg_attached | input | 1 | Debugger-attached status; gates all register access |
| bus_valid | input | 1 | Bus request strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_ack | output | 1 | Response strobe, one cycle after a request |
| bus_rdata | output | 32 | Read data, valid with bus_ack |
| trig_in | input | 8 | Level trigger inputs |
| trig_out | output | 8 | Registered trigger outputs |

## Verification
A mask write and a synchronized input edge can both reach the channel combiner in the same cycle. The bench provokes this by raising input 4 and then timing a sink-mask write for output 7 so that it lands on the same edge at which the synchronized input rises. Output 6 is already mapped to that input. The bench judges the result with two samples. One cycle after that edge both outputs must still be low. One cycle later both outputs 6 and 7 must be high together (0xC0). This shows that the new mask and the new input level are applied together, with no glitch on either side.

// File: rtl/xtrig_pkg.sv
package xtrig_pkg;
  localparam int NUM_CH     = 4;
  localparam int DATA_W     = 32;
  localparam int CTRL_OFS   = 'h00;
  localparam int SRC_BASE   = 'h20;
  localparam int SINK_BASE  = 'hA0;
  localparam int REG_STRIDE = 4;

  typedef logic [NUM_CH-1:0] chmask_t;
endpackage

// File: rtl/xtrig_sync.sv
module xtrig_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) stage_q[k] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int k = 1; k < STAGES; k++) stage_q[k] <= stage_q[k-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/xtrig_regs.sv
module xtrig_regs
  import xtrig_pkg::*;
#(
  parameter int NUM_IN  = 8,
  parameter int NUM_OUT = 8,
  parameter int ADDR_W  = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      dbg_attached,
  input  logic                      bus_valid,
  input  logic                      bus_write,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [DATA_W-1:0]         bus_wdata,
  output logic                      bus_ack,
  output logic [DATA_W-1:0]         bus_rdata,
  output logic                      en_o,
  output chmask_t [NUM_IN-1:0]      src_o,
  output chmask_t [NUM_OUT-1:0]     sink_o
);
  logic                  en_q;
  chmask_t [NUM_IN-1:0]  src_q;
  chmask_t [NUM_OUT-1:0] sink_q;
  logic [NUM_IN-1:0]     hit_src;
  logic [NUM_OUT-1:0]    hit_sink;
  logic                  hit_ctrl, hit_any;
  logic                  wr_ok, rd_ok;
  logic [DATA_W-1:0]     rd_mux;
  logic                  ack_q;
  logic [DATA_W-1:0]     rdata_q;
  logic                  unused_wdata;

  assign unused_wdata = ^bus_wdata[DATA_W-1:NUM_CH];

  assign wr_ok    = bus_valid && dbg_attached && bus_write;
  assign rd_ok    = bus_valid && dbg_attached && !bus_write;
  assign hit_ctrl = (bus_addr == ADDR_W'(CTRL_OFS));

  for (genvar i = 0; i < NUM_IN; i++) begin : g_src_dec
    assign hit_src[i] = (bus_addr == ADDR_W'(SRC_BASE + REG_STRIDE * i));
  end
  for (genvar j = 0; j < NUM_OUT; j++) begin : g_sink_dec
    assign hit_sink[j] = (bus_addr == ADDR_W'(SINK_BASE + REG_STRIDE * j));
  end
  assign hit_any = hit_ctrl || (|hit_src) || (|hit_sink);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      src_q  <= '0;
      sink_q <= '0;
    end else if (wr_ok) begin
      if (hit_ctrl) en_q <= bus_wdata[0];
      for (int i = 0; i < NUM_IN; i++)
        if (hit_src[i]) src_q[i] <= bus_wdata[NUM_CH-1:0];
      for (int j = 0; j < NUM_OUT; j++)
        if (hit_sink[j]) sink_q[j] <= bus_wdata[NUM_CH-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (hit_ctrl) rd_mux[0] = en_q;
    for (int i = 0; i < NUM_IN; i++)
      if (hit_src[i]) rd_mux[NUM_CH-1:0] = src_q[i];
    for (int j = 0; j < NUM_OUT; j++)
      if (hit_sink[j]) rd_mux[NUM_CH-1:0] = sink_q[j];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      ack_q   <= bus_valid;
      rdata_q <= rd_ok ? rd_mux : '0;
    end
  end

  assign bus_ack   = ack_q;
  assign bus_rdata = rdata_q;
  assign en_o      = en_q;
  assign src_o     = src_q;
  assign sink_o    = sink_q;

  assert_locked_write_R7: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_write && !dbg_attached) |=>
      ($stable(en_q) && $stable(src_q) && $stable(sink_q)));

  assert_locked_read_R7: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_write && !dbg_attached) |=> (bus_rdata == '0));

  assert_undef_write_R8: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_write && !hit_any) |=>
      ($stable(en_q) && $stable(src_q) && $stable(sink_q)));

  assert_ack_follows_R9: assert property (@(posedge clk) disable iff (rst)
    bus_valid |=> bus_ack);

  assert_ack_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !bus_valid |=> (!bus_ack && bus_rdata == '0));

  assert_upper_zero_R3: assert property (@(posedge clk) disable iff (rst)
    bus_ack |-> (bus_rdata[DATA_W-1:NUM_CH] == '0));
endmodule

// File: rtl/xtrig_fabric.sv
module xtrig_fabric
  import xtrig_pkg::*;
#(
  parameter int NUM_IN  = 8,
  parameter int NUM_OUT = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  en,
  input  logic [NUM_IN-1:0]     trig_s,
  input  chmask_t [NUM_IN-1:0]  src,
  input  chmask_t [NUM_OUT-1:0] sink,
  output logic [NUM_OUT-1:0]    trig_out
);
  chmask_t            chan;
  logic [NUM_OUT-1:0] out_q;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    logic [NUM_IN-1:0] feed;
    for (genvar i = 0; i < NUM_IN; i++) begin : g_feed
      assign feed[i] = trig_s[i] & src[i][c];
    end
    assign chan[c] = en & (|feed);
  end

  for (genvar j = 0; j < NUM_OUT; j++) begin : g_out
    always_ff @(posedge clk) begin
      if (rst) out_q[j] <= 1'b0;
      else     out_q[j] <= |(chan & sink[j]);
    end
  end

  assign trig_out = out_q;

  assert_disabled_low_R6: assert property (@(posedge clk) disable iff (rst)
    !en |=> (trig_out == '0));

  assert_idle_channels_R10: assert property (@(posedge clk) disable iff (rst)
    (trig_s == '0) |=> (trig_out == '0));

  assert_no_sink_R5: assert property (@(posedge clk) disable iff (rst)
    (sink == '0) |=> (trig_out == '0));
endmodule

// File: rtl/xtrig_router.sv
module xtrig_router
  import xtrig_pkg::*;
#(
  parameter int NUM_IN  = 8,
  parameter int NUM_OUT = 8,
  parameter int ADDR_W  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               dbg_attached,
  input  logic               bus_valid,
  input  logic               bus_write,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic               bus_ack,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [NUM_IN-1:0]  trig_in,
  output logic [NUM_OUT-1:0] trig_out
);
  logic                  en;
  chmask_t [NUM_IN-1:0]  src;
  chmask_t [NUM_OUT-1:0] sink;
  logic [NUM_IN-1:0]     trig_s;

  xtrig_regs #(.NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT), .ADDR_W(ADDR_W)) u_regs (
    .clk          (clk),
    .rst          (rst),
    .dbg_attached (dbg_attached),
    .bus_valid    (bus_valid),
    .bus_write    (bus_write),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_ack      (bus_ack),
    .bus_rdata    (bus_rdata),
    .en_o         (en),
    .src_o        (src),
    .sink_o       (sink)
  );

  xtrig_sync #(.W(NUM_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (trig_in),
    .q   (trig_s)
  );

  xtrig_fabric #(.NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT)) u_fabric (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .trig_s   (trig_s),
    .src      (src),
    .sink     (sink),
    .trig_out (trig_out)
  );

  assert_reset_low_R1: assert property (@(posedge clk)
    rst |=> (trig_out == '0 && bus_rdata == '0 && !bus_ack));
endmodule

// File: tb/xtrig_router_tb_top.sv
`timescale 1ns/1ps
module xtrig_router_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        dbg_attached = 1'b1;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_ack;
  logic [31:0] bus_rdata;
  logic [7:0]  trig_in = '0;
  logic [7:0]  trig_out;

  int nchk = 0;
  int nbad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  xtrig_router dut_i (
    .clk(clk), .rst(rst), .dbg_attached(dbg_attached),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .trig_in(trig_in), .trig_out(trig_out)
  );

  typedef struct packed {
    logic [2:0] ia; logic [3:0] ma;
    logic [2:0] ib; logic [3:0] mb;
    logic [2:0] oi; logic [3:0] om;
    logic [7:0] trig; logic [7:0] expv;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{3'd4, 4'b0001, 3'd0, 4'b0000, 3'd6, 4'b0001, 8'h10, 8'h40},
    '{3'd4, 4'b0001, 3'd0, 4'b0000, 3'd6, 4'b0010, 8'h10, 8'h00},
    '{3'd4, 4'b0010, 3'd1, 4'b0100, 3'd7, 4'b0100, 8'h02, 8'h80},
    '{3'd4, 4'b0010, 3'd1, 4'b0100, 3'd7, 4'b0100, 8'h10, 8'h00},
    '{3'd3, 4'b1000, 3'd5, 4'b1000, 3'd0, 4'b1000, 8'h20, 8'h01},
    '{3'd2, 4'b1111, 3'd7, 4'b0000, 3'd3, 4'b0001, 8'h84, 8'h08},
    '{3'd2, 4'b0000, 3'd7, 4'b0110, 3'd5, 4'b0100, 8'h84, 8'h20},
    '{3'd0, 4'b0011, 3'd1, 4'b0011, 3'd2, 4'b1100, 8'h03, 8'h00}
  };

  function automatic logic [7:0] src_adr(input int i);
    return 8'(8'h20 + 4 * i);
  endfunction
  function automatic logic [7:0] sink_adr(input int j);
    return 8'(8'hA0 + 4 * j);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d, output logic ak);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata; ak = bus_ack;
    bus_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nbad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    logic        ak;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    check("R1 outputs", {24'h0, trig_out}, 32'h0);
    bus_rd(8'h00, rd, ak); check("R1 ctrl", rd, 32'h0);
    check("R9 ack", {31'h0, ak}, 32'h1);
    @(negedge clk); check("R9 ack idle", {31'h0, bus_ack}, 32'h0);
    bus_rd(src_adr(4), rd, ak); check("R1 src4", rd, 32'h0);

    // R2, R3, R4: register fields
    bus_wr(8'h00, 32'hFFFF_FFFF);
    bus_rd(8'h00, rd, ak); check("R2 ctrl readback", rd, 32'h1);
    bus_wr(src_adr(7), 32'hFFFF_FFF5);
    bus_rd(src_adr(7), rd, ak); check("R3 src7 readback", rd, 32'h5);
    bus_wr(sink_adr(0), 32'hABCD_EF0A);
    bus_rd(sink_adr(0), rd, ak); check("R4 sink0 readback", rd, 32'hA);
    bus_wr(src_adr(7), 32'h0);
    bus_wr(sink_adr(0), 32'h0);

    // R8: undefined offsets
    bus_wr(8'h04, 32'hFFFF_FFFF);
    bus_wr(8'h40, 32'hFFFF_FFFF);
    bus_wr(8'h21, 32'hFFFF_FFFF);
    bus_wr(8'hC0, 32'hFFFF_FFFF);
    bus_rd(8'h04, rd, ak); check("R8 read 0x04", rd, 32'h0);
    bus_rd(8'h21, rd, ak); check("R8 read 0x21", rd, 32'h0);
    bus_rd(src_adr(0), rd, ak); check("R8 src0 untouched", rd, 32'h0);
    bus_rd(8'h00, rd, ak); check("R8 ctrl untouched", rd, 32'h1);

    // R5 / R10: vector table
    foreach (VECS[k]) begin
      bus_wr(src_adr(int'(VECS[k].ia)), {28'h0, VECS[k].ma});
      bus_wr(src_adr(int'(VECS[k].ib)), {28'h0, VECS[k].mb});
      bus_wr(sink_adr(int'(VECS[k].oi)), {28'h0, VECS[k].om});
      @(negedge clk); trig_in = VECS[k].trig;
      repeat (3) @(negedge clk);
      check($sformatf("R5/R10 vector %0d", k), {24'h0, trig_out}, {24'h0, VECS[k].expv});
      trig_in = '0;
      bus_wr(src_adr(int'(VECS[k].ia)), 32'h0);
      bus_wr(src_adr(int'(VECS[k].ib)), 32'h0);
      bus_wr(sink_adr(int'(VECS[k].oi)), 32'h0);
      repeat (3) @(negedge clk);
    end

    // R5: latency of three edges
    bus_wr(src_adr(4), 32'h1);
    bus_wr(sink_adr(6), 32'h1);
    @(negedge clk); trig_in = 8'h10;
    repeat (2) @(negedge clk); check("R5 not yet", {24'h0, trig_out}, 32'h0);
    @(negedge clk); check("R5 third edge", {24'h0, trig_out}, 32'h40);
    trig_in = 8'h00;
    repeat (2) @(negedge clk); check("R5 fall held", {24'h0, trig_out}, 32'h40);
    @(negedge clk); check("R5 fall", {24'h0, trig_out}, 32'h0);

    // R7: access lock keeps routing alive
    dbg_attached = 1'b0;
    bus_wr(sink_adr(7), 32'h1);
    bus_rd(sink_adr(6), rd, ak); check("R7 locked read", rd, 32'h0);
    @(negedge clk); trig_in = 8'h10;
    repeat (3) @(negedge clk); check("R7 routing while locked", {24'h0, trig_out}, 32'h40);
    dbg_attached = 1'b1;
    bus_rd(sink_adr(6), rd, ak); check("R7 sink6 kept", rd, 32'h1);
    bus_rd(sink_adr(7), rd, ak); check("R7 sink7 dropped", rd, 32'h0);

    // R6: disable forces outputs low one edge after the write
    bus_wr(8'h00, 32'h0);
    check("R6 before", {24'h0, trig_out}, 32'h40);
    @(negedge clk); check("R6 disabled", {24'h0, trig_out}, 32'h0);
    bus_wr(8'h00, 32'h1);
    @(negedge clk); check("R6 re-enabled", {24'h0, trig_out}, 32'h40);
    trig_in = 8'h00;
    repeat (4) @(negedge clk);

    // R5 / R10: mask write and synchronized input edge on the same edge
    @(negedge clk); trig_in = 8'h10;
    bus_wr(sink_adr(7), 32'h1);
    check("R5 same-edge hold", {24'h0, trig_out}, 32'h0);
    @(negedge clk); check("R10 same-edge both", {24'h0, trig_out}, 32'hC0);

    // R1: reset clears configuration
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1 outputs after reset", {24'h0, trig_out}, 32'h0);
    bus_rd(sink_adr(7), rd, ak); check("R1 sink7 after reset", rd, 32'h0);

    finish_run();
  end
endmodule